// File: doc/BRIEF.md
# Second-Operand Barrel Shifter

This block forms the second operand of a data-processing operation, together with the shifter carry that the flag logic may consume. Each cycle that `in_valid` is high, it takes one of two paths. In the first, a full-width constant on `const_val` goes straight to the output. In the second, the register value `rm_val` is shifted or rotated by an amount that comes from one of two places. One is a small immediate field. The other is the low byte of a second register value. Each source has its own rules for zero and out-of-range amounts.

The result and carry are captured in an output register, so they appear one cycle after the request. `out_valid` marks the cycle in which they appear. The width `DATA_W` is a parameter and must be a power of two from 8 to 128. The immediate amount field is log2(`DATA_W`) bits wide. In the text below, W stands for `DATA_W`.

Top module: `barrel_operand_shifter`

## Requirements
- R1: When `use_const` is 1, `op_out` equals `const_val` and `carry_out` equals `carry_in`, whatever the kind, amount source or amounts are.
- R2: A register-sourced amount uses only bits [7:0] of `reg_amt`; higher bits have no effect. An amount of 0 returns `rm_val` unchanged, with `carry_out` equal to `carry_in`.
- R3: Kind 2'b00 is logical left. For an amount n from 1 to W-1 the result is `rm_val` shifted left by n, and the carry is bit W-n. For n = W the result is 0 and the carry is bit 0. For n > W both the result and the carry are 0.
- R4: Kind 2'b01 is logical right. For n from 1 to W-1 the carry is bit n-1. For n = W the result is 0 and the carry is bit W-1. For n > W both the result and the carry are 0.
- R5: Kind 2'b10 is arithmetic right and fills with the sign bit. For n >= W every result bit is the sign bit, and the carry is the sign bit.
- R6: Kind 2'b11 is rotate right by n modulo W, and the carry is result bit W-1. A nonzero register amount that is a multiple of W leaves the value unchanged, with the carry equal to bit W-1.
- R7: With an immediate amount (`amt_from_reg` = 0), a value of 0 means "no shift" for logical left, which passes the carry through. For logical right and arithmetic right, 0 means a shift by W.
- R8: An immediate amount of 0 with rotate right selects the extended rotate. The result is `{carry_in, rm_val[W-1:1]}`, and the carry is `rm_val[0]`.
- R9: Outputs are registered. `out_valid` equals `in_valid` delayed by one cycle. `op_out` and `carry_out` hold their values while `in_valid` is 0. Reset clears all three outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| use_const | input | 1 | 1 selects the constant path |
| const_val | input | DATA_W | Constant operand |
| amt_from_reg | input | 1 | 1: amount from `reg_amt[7:0]`; 0: from `imm_amt` |
| kind | input | 2 | 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| imm_amt | input | log2(DATA_W) | Immediate shift amount |
| reg_amt | input | DATA_W | Register supplying the shift amount |
| rm_val | input | DATA_W | Value to be shifted |
| carry_in | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| op_out | output | DATA_W | Shifted or constant operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The bench builds two instances. The first uses `DATA_W` = 8. At that width every immediate amount, every value and every register amount from 0 to 255 can be swept for all four kinds and both carry values. That covers the "equal to W", "above W" and "multiple of W" corners exhaustively. The second instance uses the default width of 32. It checks the same corners at full width and shows that the bits of `reg_amt` above bit 7 are ignored, which the 8-bit build cannot show.

// File: rtl/bshift_pkg.sv
// Package: shared types for the second-operand barrel shifter.
// Assumes: the kind encoding below is fixed by the instruction decoder upstream.
package bshift_pkg;

    typedef enum logic [1:0] {
        SHK_LSL = 2'b00,
        SHK_LSR = 2'b01,
        SHK_ASR = 2'b10,
        SHK_ROR = 2'b11
    } shift_kind_e;

    // Number of low register bits that form a register-sourced amount
    localparam int REG_AMT_BITS = 8;

endpackage

// File: rtl/bs_amount_decode.sv
// Module: bs_amount_decode
// Turns the immediate or register-sourced amount into a clamped amount
// (0..DATA_W+1), a rotate amount (modulo DATA_W) and two special-case flags.
// Assumes: DATA_W is a power of two between 8 and 128.
module bs_amount_decode
    import bshift_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W),
    localparam int CL_W  = $clog2(DATA_W + 2)
) (
    input  logic                     amt_from_reg,
    input  shift_kind_e              kind,
    input  logic [SH_W-1:0]          imm_amt,
    input  logic [REG_AMT_BITS-1:0]  reg_byte,
    output logic [CL_W-1:0]          amt_clamp,
    output logic [SH_W-1:0]          rot_amt,
    output logic                     is_rrx,
    output logic                     no_shift
);

    localparam int FULL = DATA_W;
    localparam int OVER = DATA_W + 1;

    logic imm_zero;
    logic reg_zero;
    logic reg_over;

    assign imm_zero = (imm_amt == '0);
    assign reg_zero = (reg_byte == '0);
    assign reg_over = (int'(reg_byte) > FULL);

    // Select the amount source and apply its edge-case rules
    always_comb begin
        if (amt_from_reg) begin
            is_rrx    = 1'b0;
            no_shift  = reg_zero;
            rot_amt   = reg_byte[SH_W-1:0];
            amt_clamp = reg_over ? CL_W'(OVER) : CL_W'(reg_byte);
        end else begin
            is_rrx    = imm_zero && (kind == SHK_ROR);
            no_shift  = imm_zero && (kind == SHK_LSL);
            rot_amt   = imm_amt;
            amt_clamp = imm_zero ? CL_W'(FULL) : CL_W'(imm_amt);
        end
    end

endmodule

// File: rtl/bs_rotate.sv
// Module: bs_rotate
// Logarithmic rotate-right network: one stage per bit of the amount.
// Assumes: DATA_W is a power of two.
module bs_rotate #(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [SH_W-1:0]   amt,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] stage [SH_W+1];

    assign stage[0] = din;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int S = 1 << k;
        // Rotate by 2**k when amount bit k is set
        assign stage[k+1] = amt[k] ? {stage[k][S-1:0], stage[k][DATA_W-1:S]}
                                   : stage[k];
    end

    assign dout = stage[SH_W];

endmodule

// File: rtl/bs_shift_core.sv
// Module: bs_shift_core
// Computes the shifted value and shifter carry for one decoded request.
// Assumes: amt_clamp is in 0..DATA_W+1, where DATA_W+1 stands for "beyond the width".
module bs_shift_core
    import bshift_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W),
    localparam int CL_W  = $clog2(DATA_W + 2)
) (
    input  logic [DATA_W-1:0] value,
    input  logic              cin,
    input  shift_kind_e       kind,
    input  logic [CL_W-1:0]   amt_clamp,
    input  logic [SH_W-1:0]   rot_amt,
    input  logic              is_rrx,
    input  logic              no_shift,
    output logic [DATA_W-1:0] res,
    output logic              cout
);

    localparam int W2 = 2 * DATA_W;

    logic [W2-1:0]     lsl_w;
    logic [W2-1:0]     lsr_w;
    logic [W2-1:0]     asr_w;
    logic [CL_W-1:0]   asr_amt;
    logic [DATA_W-1:0] rot_out;
    logic              over;

    assign over    = (int'(amt_clamp) > DATA_W);
    assign asr_amt = over ? CL_W'(DATA_W) : amt_clamp;

    // Double-width shifts keep the last bit shifted out next to the result
    assign lsl_w = {{DATA_W{1'b0}}, value} << amt_clamp;
    assign lsr_w = {value, {DATA_W{1'b0}}} >> amt_clamp;
    assign asr_w = $signed({value, {DATA_W{1'b0}}}) >>> asr_amt;

    bs_rotate #(.DATA_W(DATA_W)) u_rot (
        .din  (value),
        .amt  (rot_amt),
        .dout (rot_out)
    );

    // Pick the result for the kind, then apply the special cases
    always_comb begin
        unique case (kind)
            SHK_LSL: begin
                res  = over ? '0 : lsl_w[DATA_W-1:0];
                cout = over ? 1'b0 : lsl_w[DATA_W];
            end
            SHK_LSR: begin
                res  = over ? '0 : lsr_w[W2-1:DATA_W];
                cout = over ? 1'b0 : lsr_w[DATA_W-1];
            end
            SHK_ASR: begin
                res  = asr_w[W2-1:DATA_W];
                cout = asr_w[DATA_W-1];
            end
            default: begin
                res  = rot_out;
                cout = rot_out[DATA_W-1];
            end
        endcase
        if (is_rrx) begin
            res  = {cin, value[DATA_W-1:1]};
            cout = value[0];
        end
        if (no_shift) begin
            res  = value;
            cout = cin;
        end
    end

endmodule

// File: rtl/bs_out_reg.sv
// Module: bs_out_reg
// Output stage: registers the result and carry on a valid request and delays valid by one cycle.
// Assumes: synchronous active-low reset.
module bs_out_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] d_res,
    input  logic              d_cout,
    output logic              out_valid,
    output logic [DATA_W-1:0] op_out,
    output logic              carry_out
);

    // Capture on valid, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            op_out    <= '0;
            carry_out <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                op_out    <= d_res;
                carry_out <= d_cout;
            end
        end
    end

endmodule

// File: rtl/barrel_operand_shifter.sv
// Module: barrel_operand_shifter (top)
// Forms the second operand: either a constant passed through, or a register value
// shifted by an immediate or register-sourced amount. Result registered, one-cycle latency.
// Assumes: DATA_W is a power of two from 8 to 128; kind encoding per bshift_pkg.
module barrel_operand_shifter
    import bshift_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W),
    localparam int CL_W  = $clog2(DATA_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              use_const,
    input  logic [DATA_W-1:0] const_val,
    input  logic              amt_from_reg,
    input  logic [1:0]        kind,
    input  logic [SH_W-1:0]   imm_amt,
    input  logic [DATA_W-1:0] reg_amt,
    input  logic [DATA_W-1:0] rm_val,
    input  logic              carry_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] op_out,
    output logic              carry_out
);

    shift_kind_e       kind_e;
    logic [CL_W-1:0]   amt_clamp;
    logic [SH_W-1:0]   rot_amt;
    logic              is_rrx;
    logic              no_shift;
    logic [DATA_W-1:0] core_res;
    logic              core_cout;
    logic [DATA_W-1:0] sel_res;
    logic              sel_cout;

    assign kind_e = shift_kind_e'(kind);

    bs_amount_decode #(.DATA_W(DATA_W)) u_dec (
        .amt_from_reg (amt_from_reg),
        .kind         (kind_e),
        .imm_amt      (imm_amt),
        .reg_byte     (reg_amt[REG_AMT_BITS-1:0]),
        .amt_clamp    (amt_clamp),
        .rot_amt      (rot_amt),
        .is_rrx       (is_rrx),
        .no_shift     (no_shift)
    );

    bs_shift_core #(.DATA_W(DATA_W)) u_core (
        .value     (rm_val),
        .cin       (carry_in),
        .kind      (kind_e),
        .amt_clamp (amt_clamp),
        .rot_amt   (rot_amt),
        .is_rrx    (is_rrx),
        .no_shift  (no_shift),
        .res       (core_res),
        .cout      (core_cout)
    );

    // Constant path bypasses the shifter and passes the carry through
    assign sel_res  = use_const ? const_val : core_res;
    assign sel_cout = use_const ? carry_in  : core_cout;

    bs_out_reg #(.DATA_W(DATA_W)) u_oreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .d_res     (sel_res),
        .d_cout    (sel_cout),
        .out_valid (out_valid),
        .op_out    (op_out),
        .carry_out (carry_out)
    );

endmodule

// File: rtl/bshift_checker.sv
// Module: bshift_checker
// Port-level properties of barrel_operand_shifter, attached with bind.
// Assumes: synchronous active-low reset; kind 2'b11 is rotate right.
module bshift_checker #(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              use_const,
    input logic [DATA_W-1:0] const_val,
    input logic              amt_from_reg,
    input logic [1:0]        kind,
    input logic [SH_W-1:0]   imm_amt,
    input logic [DATA_W-1:0] reg_amt,
    input logic [DATA_W-1:0] rm_val,
    input logic              carry_in,
    input logic              out_valid,
    input logic [DATA_W-1:0] op_out,
    input logic              carry_out
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(op_out) && $stable(carry_out))); // R9

    AST_CONST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && use_const) |=>
        (op_out == $past(const_val) && carry_out == $past(carry_in))); // R1

    AST_REG_ZERO_AMT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !use_const && amt_from_reg && reg_amt[7:0] == 8'd0) |=>
        (op_out == $past(rm_val) && carry_out == $past(carry_in))); // R2

    AST_EXT_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !use_const && !amt_from_reg && kind == 2'b11 && imm_amt == '0) |=>
        (op_out[DATA_W-1] == $past(carry_in) && carry_out == $past(rm_val[0]))); // R8

endmodule

bind barrel_operand_shifter bshift_checker #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .use_const    (use_const),
    .const_val    (const_val),
    .amt_from_reg (amt_from_reg),
    .kind         (kind),
    .imm_amt      (imm_amt),
    .reg_amt      (reg_amt),
    .rm_val       (rm_val),
    .carry_in     (carry_in),
    .out_valid    (out_valid),
    .op_out       (op_out),
    .carry_out    (carry_out)
);

// File: tb/barrel_operand_shifter_tb.sv
module barrel_operand_shifter_tb;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Instance A: DATA_W = 8
    logic       a_iv = 0, a_uc = 0, a_fr = 0, a_cin = 0;
    logic [1:0] a_kind = 0;
    logic [2:0] a_imm = 0;
    logic [7:0] a_const = 0, a_reg = 0, a_rm = 0;
    logic       a_ov, a_co;
    logic [7:0] a_op;

    // Instance B: DATA_W = 32
    logic        b_iv = 0, b_uc = 0, b_fr = 0, b_cin = 0;
    logic [1:0]  b_kind = 0;
    logic [4:0]  b_imm = 0;
    logic [31:0] b_const = 0, b_reg = 0, b_rm = 0;
    logic        b_ov, b_co;
    logic [31:0] b_op;

    barrel_operand_shifter #(.DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(a_iv), .use_const(a_uc),
        .const_val(a_const), .amt_from_reg(a_fr), .kind(a_kind), .imm_amt(a_imm),
        .reg_amt(a_reg), .rm_val(a_rm), .carry_in(a_cin),
        .out_valid(a_ov), .op_out(a_op), .carry_out(a_co));

    barrel_operand_shifter #(.DATA_W(32)) u_dut32 (
        .clk(clk), .rst_n(rst_n), .in_valid(b_iv), .use_const(b_uc),
        .const_val(b_const), .amt_from_reg(b_fr), .kind(b_kind), .imm_amt(b_imm),
        .reg_amt(b_reg), .rm_val(b_rm), .carry_in(b_cin),
        .out_valid(b_ov), .op_out(b_op), .carry_out(b_co));

    // Reference: bit-by-bit shift of width w by amount n; returns {carry, result}
    function automatic logic [32:0] model(int w, logic [31:0] v, int k, int n,
                                          logic cin, bit rrx);
        logic [31:0] r = '0;
        logic        c = cin;
        int          m;
        if (rrx) begin
            for (int i = 0; i < w - 1; i++) r[i] = v[i+1];
            r[w-1] = cin;
            c = v[0];
        end else if (n == 0) begin
            r = v;
        end else begin
            case (k)
                0: begin
                    for (int i = 0; i < w; i++) if (i >= n) r[i] = v[i-n];
                    c = 1'b0;
                    if (n <= w) c = v[w-n];
                end
                1: begin
                    for (int i = 0; i < w; i++) if (i + n < w) r[i] = v[i+n];
                    c = 1'b0;
                    if (n <= w) c = v[n-1];
                end
                2: begin
                    for (int i = 0; i < w; i++) r[i] = (i + n < w) ? v[i+n] : v[w-1];
                    c = v[w-1];
                    if (n <= w) c = v[n-1];
                end
                default: begin
                    m = n % w;
                    if (m == 0) begin
                        r = v;
                        c = v[w-1];
                    end else begin
                        for (int i = 0; i < w; i++) r[i] = v[(i+m)%w];
                        c = v[m-1];
                    end
                end
            endcase
        end
        return {c, r};
    endfunction

    function automatic string req_of(int k);
        case (k)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string req, logic [32:0] got, logic [32:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One request on instance A, checked one cycle later
    task automatic run_a(logic fr, int k, int imm, int ra, logic [7:0] rm, logic cin);
        logic [32:0] e;
        string       req;
        int          n;
        bit          rrx;
        @(negedge clk);
        a_iv = 1; a_uc = 0; a_fr = fr; a_kind = 2'(k); a_imm = 3'(imm);
        a_reg = 8'(ra); a_rm = rm; a_cin = cin;
        rrx = 0;
        req = req_of(k);
        if (fr) begin
            n = ra;
            if (ra == 0) req = "R2";
        end else begin
            n = imm;
            if (imm == 0) begin
                req = "R7";
                if (k == 1 || k == 2) n = 8;
                if (k == 3) begin rrx = 1; req = "R8"; end
            end
        end
        e = model(8, {24'd0, rm}, k, n, cin, rrx);
        @(negedge clk);
        check(req, {24'd0, a_co, a_op}, {24'd0, e[32], e[7:0]});
        check("R9", {32'd0, a_ov}, 33'd1);
    endtask

    // One request on instance B, checked one cycle later
    task automatic run_b(logic fr, int k, int imm, logic [31:0] ra, logic [31:0] rm,
                         logic cin, string req);
        logic [32:0] e;
        int          n;
        bit          rrx = 0;
        @(negedge clk);
        b_iv = 1; b_uc = 0; b_fr = fr; b_kind = 2'(k); b_imm = 5'(imm);
        b_reg = ra; b_rm = rm; b_cin = cin;
        if (fr) n = int'(ra[7:0]);
        else begin
            n = imm;
            if (imm == 0 && (k == 1 || k == 2)) n = 32;
            if (imm == 0 && k == 3) rrx = 1;
        end
        e = model(32, rm, k, n, cin, rrx);
        @(negedge clk);
        check(req, {b_co, b_op}, e);
    endtask

    logic [7:0] vals [8] = '{8'h00, 8'hFF, 8'h80, 8'h01, 8'h5A, 8'hA5, 8'h7F, 8'hC3};

    initial begin : main
        repeat (3) @(negedge clk);
        // R9: reset clears outputs
        check("R9", {31'd0, a_ov, a_co}, 33'd0);
        check("R9", {8'd0, a_op, 17'd0}, 33'd0);
        check("R9", {b_co, b_op}, 33'd0);
        check("R9", {32'd0, b_ov}, 33'd0);
        rst_n = 1;

        // Immediate amounts: all values, kinds, amounts, carries (R3..R8)
        for (int v = 0; v < 256; v++)
            for (int k = 0; k < 4; k++)
                for (int im = 0; im < 8; im++)
                    for (int c = 0; c < 2; c++)
                        run_a(1'b0, k, im, 0, 8'(v), 1'(c));

        // Register amounts: full 0..255 sweep (R2..R6)
        for (int vi = 0; vi < 8; vi++)
            for (int k = 0; k < 4; k++)
                for (int ra = 0; ra < 256; ra++)
                    for (int c = 0; c < 2; c++)
                        run_a(1'b1, k, 0, ra, vals[vi], 1'(c));

        // R1: constant path ignores kind and amounts
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            a_iv = 1; a_uc = 1; a_const = 8'(8'h3C + k); a_kind = 2'(k);
            a_fr = 1'(k); a_reg = 8'd9; a_imm = 3'd0; a_rm = 8'hF0; a_cin = 1'(k);
            @(negedge clk);
            check("R1", {24'd0, a_co, a_op}, {24'd0, 1'(k), 8'(8'h3C + k)});
        end

        // R9: idle cycles hold outputs and drop valid
        @(negedge clk);
        a_iv = 0; a_uc = 0; a_fr = 1; a_reg = 8'd3; a_rm = 8'h11; a_cin = 0;
        @(negedge clk);
        @(negedge clk);
        check("R9", {24'd0, a_co, a_op}, {24'd0, 1'b1, 8'h3F});
        check("R9", {32'd0, a_ov}, 33'd0);

        // Width 32 corners
        run_b(1'b1, 0, 0, 32'hFFFF_FF04, 32'h8000_0001, 1'b0, "R2");
        run_b(1'b1, 1, 0, 32'h0000_0100, 32'h1234_5678, 1'b1, "R2");
        run_b(1'b1, 0, 0, 32'd32, 32'h0000_0001, 1'b0, "R3");
        run_b(1'b1, 0, 0, 32'd33, 32'hFFFF_FFFF, 1'b1, "R3");
        run_b(1'b1, 1, 0, 32'd32, 32'h8000_0000, 1'b0, "R4");
        run_b(1'b1, 1, 0, 32'd40, 32'hFFFF_FFFF, 1'b1, "R4");
        run_b(1'b1, 2, 0, 32'd200, 32'h8000_0000, 1'b0, "R5");
        run_b(1'b1, 2, 0, 32'd7, 32'h8765_4321, 1'b0, "R5");
        run_b(1'b1, 3, 0, 32'd64, 32'h8000_0002, 1'b0, "R6");
        run_b(1'b1, 3, 0, 32'd36, 32'h0000_000F, 1'b0, "R6");
        run_b(1'b0, 0, 0, 32'd0, 32'hDEAD_BEEF, 1'b1, "R7");
        run_b(1'b0, 1, 0, 32'd0, 32'h8000_0000, 1'b0, "R7");
        run_b(1'b0, 2, 0, 32'd0, 32'h4000_0000, 1'b1, "R7");
        run_b(1'b0, 3, 0, 32'd0, 32'h0000_0003, 1'b1, "R8");
        run_b(1'b0, 0, 31, 32'd0, 32'h0000_0003, 1'b0, "R3");

        @(negedge clk);
        b_iv = 0; a_iv = 0;
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule